// File: doc/BRIEF.md
# Sparse Configuration-Space Access Bridge

This bridge sits between a CPU load/store port and a PCI configuration-space port. The CPU reaches configuration registers through a sparse address window in which every byte of configuration address is spread over 32 bytes of CPU address. The bridge strips that spreading and then splits the result into a function number, a dword-aligned register offset and a device number. The device number is found from a one-hot select field: the lowest set bit wins. The bus number comes from a one-bit control register.

Each accepted access becomes a single registered request toward the downstream port, which answers with a ready pulse. The bridge then completes the access to the CPU with a one-cycle done pulse that carries the read data. Only one access can be in flight at a time, and a busy output holds the CPU off until it ends. The bridge handles only the primary bus. An access made while the control bit selects any other bus issues no cycle, sets a sticky error flag and completes at once with zero data.

Top module: `cfg_bridge`

## Requirements
- R1: After reset, cfg_req, cpu_busy, cpu_done and err_flag are 0 and the bus-select control bit is 0.
- R2: The CPU address is shifted right by 5 before decoding. cfg_reg is shifted bits [7:2] followed by two zero bits, so cfg_reg[1:0] is always 0.
- R3: cfg_func is shifted address bits [10:8].
- R4: cfg_dev is the index of the lowest set bit among shifted address bits [31:11], where bit 11 is device 0 and bit 31 is device 20.
- R5: When none of shifted bits [31:11] is set, cfg_dev is 0 and the cycle is still issued.
- R6: The bus number is bit 0 of the control register (written with ctl_we/ctl_bus_sel). An access made while it is 1 issues no cfg_req. On the next cycle it gives cpu_done=1 with cpu_rdata=0 and sets err_flag.
- R7: cfg_we, cfg_wdata and cfg_be carry cpu_we, cpu_wdata and cpu_be of the accepted access unchanged.
- R8: cfg_req rises on the cycle after an access is accepted. Until the cycle in which cfg_rdy is seen, cfg_req and all cfg_* fields stay stable.
- R9: cpu_busy is 1 while a request is outstanding. A cpu_req seen while busy is dropped and produces no later cycle.
- R10: At the clock edge where cfg_req and cfg_rdy are both 1, cfg_rdata is captured. The next cycle shows cpu_done=1 for one cycle and cpu_rdata holding the captured value for a read, or 0 for a write.
- R11: err_flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the bus-select control bit |
| ctl_bus_sel | input | 1 | New bus-select value (0 = primary bus) |
| cpu_req | input | 1 | CPU access request, taken when cpu_busy is 0 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Sparse byte address within the window |
| cpu_wdata | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte enables |
| cpu_busy | output | 1 | A request is outstanding |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done |
| err_flag | output | 1 | Sticky error for an access to a non-primary bus |
| cfg_req | output | 1 | Request to the downstream configuration port |
| cfg_we | output | 1 | Request is a write |
| cfg_dev | output | 5 | Decoded device number |
| cfg_func | output | 3 | Decoded function number |
| cfg_reg | output | 8 | Dword-aligned register offset |
| cfg_wdata | output | DATA_W | Forwarded write data |
| cfg_be | output | DATA_W/8 | Forwarded byte enables |
| cfg_rdy | input | 1 | Downstream acknowledge |
| cfg_rdata | input | DATA_W | Downstream read data |

## Verification
The assertions assume that the downstream port raises cfg_rdy only while cfg_req is high and holds it for exactly one clock edge. The bench's responder model works that way, adding a random delay of zero to three cycles before answering. The checks on completion assume that the CPU side changes cpu_req only between clock edges. The stimulus meets this by driving every input on the falling edge. The random addresses mix tag fields that have many bits set, a single bit set or no bit set, and an extra request is kept high during a busy period to cover the drop rule.

// File: rtl/cfg_bridge.sv
module cfg_bridge #(
  parameter int ADDR_W  = 37,
  parameter int DATA_W  = 32,
  parameter int SHIFT   = 5,
  parameter int NUM_DEV = 21,
  parameter int DEV_LSB = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic                ctl_bus_sel,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  output logic                cpu_busy,
  output logic                cpu_done,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                err_flag,
  output logic                cfg_req,
  output logic                cfg_we,
  output logic [4:0]          cfg_dev,
  output logic [2:0]          cfg_func,
  output logic [7:0]          cfg_reg,
  output logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W/8-1:0] cfg_be,
  input  logic                cfg_rdy,
  input  logic [DATA_W-1:0]   cfg_rdata
);
  localparam int SA_W = ADDR_W - SHIFT;

  logic [SA_W-1:0] sa;
  logic [4:0]      dev_c;
  logic            bus_sel;

  assign sa       = cpu_addr[ADDR_W-1:SHIFT];
  assign cpu_busy = cfg_req;

  always_comb begin
    dev_c = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--)
      if (sa[DEV_LSB + i]) dev_c = 5'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_sel   <= 1'b0;
      err_flag  <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_dev   <= '0;
      cfg_func  <= '0;
      cfg_reg   <= '0;
      cfg_wdata <= '0;
      cfg_be    <= '0;
    end else begin
      cpu_done <= 1'b0;
      if (ctl_we) bus_sel <= ctl_bus_sel;
      if (cfg_req) begin
        if (cfg_rdy) begin
          cfg_req   <= 1'b0;
          cpu_done  <= 1'b1;
          cpu_rdata <= cfg_we ? '0 : cfg_rdata;
        end
      end else if (cpu_req) begin
        if (bus_sel) begin
          err_flag  <= 1'b1;
          cpu_done  <= 1'b1;
          cpu_rdata <= '0;
        end else begin
          cfg_req   <= 1'b1;
          cfg_we    <= cpu_we;
          cfg_dev   <= dev_c;
          cfg_func  <= sa[10:8];
          cfg_reg   <= {sa[7:2], 2'b00};
          cfg_wdata <= cpu_wdata;
          cfg_be    <= cpu_be;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_bridge_chk.sv
module cfg_bridge_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_DEV = 21
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cpu_req,
  input logic                cpu_done,
  input logic                err_flag,
  input logic                bus_sel,
  input logic                cfg_req,
  input logic                cfg_rdy,
  input logic                cfg_we,
  input logic [4:0]          cfg_dev,
  input logic [2:0]          cfg_func,
  input logic [7:0]          cfg_reg,
  input logic [DATA_W-1:0]   cfg_wdata,
  input logic [DATA_W/8-1:0] cfg_be
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_rdy |=> cfg_req && $stable(cfg_dev) && $stable(cfg_func)
      && $stable(cfg_reg) && $stable(cfg_we) && $stable(cfg_wdata) && $stable(cfg_be));

  assert_reg_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_reg[1:0] == 2'b00);

  assert_dev_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_dev < 5'(NUM_DEV));

  assert_no_cycle_bus1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> !$past(bus_sel));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> $past(cfg_req && cfg_rdy) || $past(cpu_req && !cfg_req && bus_sel));
endmodule

bind cfg_bridge cfg_bridge_chk #(.DATA_W(DATA_W), .NUM_DEV(NUM_DEV)) chk (.*);

// File: tb/cfg_bridge_test.sv
module cfg_bridge_test;
  localparam int ADDR_W = 37;
  localparam int DATA_W = 32;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_bus_sel = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [3:0] cpu_be = '0;
  logic cpu_busy, cpu_done, err_flag, cfg_req, cfg_we;
  logic [DATA_W-1:0] cpu_rdata, cfg_wdata;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_func;
  logic [7:0] cfg_reg;
  logic [3:0] cfg_be;
  logic cfg_rdy = 0;
  logic [DATA_W-1:0] cfg_rdata = '0;

  int total = 0, bad = 0;
  logic [31:0] mem [64];
  logic [31:0] last_rdata;
  int lat = 0;
  bit exp_bus = 0;

  always #2 clk = ~clk;

  cfg_bridge uut (.*);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // downstream port model
  always @(negedge clk) begin
    if (cfg_rdy) cfg_rdy = 0;
    else if (cfg_req) begin
      if (lat == 0) begin
        cfg_rdata = mem[cfg_reg[7:2]] ^ (32'(cfg_dev) << 16) ^ (32'(cfg_func) << 8);
        last_rdata = cfg_rdata;
        if (cfg_we)
          for (int b = 0; b < 4; b++)
            if (cfg_be[b]) mem[cfg_reg[7:2]][8*b +: 8] = cfg_wdata[8*b +: 8];
        cfg_rdy = 1;
        lat = int'($urandom % 4);
      end else lat--;
    end
  end

  function automatic logic [ADDR_W-1:0] mk_addr(logic [20:0] sel, logic [2:0] f,
                                               logic [5:0] r, logic [6:0] junk);
    logic [31:0] s;
    s = {sel, f, r, junk[1:0]};
    return {s, junk[6:2]};
  endfunction

  function automatic logic [4:0] exp_dev(logic [ADDR_W-1:0] a);
    for (int i = 0; i < 21; i++)
      if (a[5 + 11 + i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic set_bus(bit v);
    @(negedge clk);
    ctl_we = 1; ctl_bus_sel = v;
    @(negedge clk);
    ctl_we = 0;
    exp_bus = v;
  endtask

  task automatic access(bit we, logic [ADDR_W-1:0] a, logic [31:0] wd, logic [3:0] be, bit hold);
    int n;
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    @(negedge clk);
    if (hold) cpu_addr = a ^ {5'd0, 32'hFFFF_FF00};
    else cpu_req = 0;
    if (exp_bus) begin
      cpu_req = 0;
      chk(cpu_done && err_flag && cpu_rdata == 0 && !cfg_req, "R6 bus1 access",
          {cpu_done, err_flag, cfg_req, cpu_rdata}, {3'b110, 32'd0});
      return;
    end
    chk(cfg_req && cpu_busy, "R8/R9 request and busy", {cfg_req, cpu_busy}, 2'b11);
    chk(cfg_reg == {a[12:7], 2'b00}, "R2 register", cfg_reg, {a[12:7], 2'b00});
    chk(cfg_func == a[15:13], "R3 function", cfg_func, a[15:13]);
    chk(cfg_dev == exp_dev(a), (a[36:16] == 0) ? "R5 no select bit" : "R4 device",
        cfg_dev, exp_dev(a));
    chk(cfg_we == we && cfg_be == be && (!we || cfg_wdata == wd), "R7 forward",
        {cfg_we, cfg_be, cfg_wdata}, {we, be, we ? wd : cfg_wdata});
    if (hold) begin
      @(negedge clk);
      cpu_req = 0;
    end
    n = 0;
    while (!cpu_done && n < 50) begin @(negedge clk); n++; end
    chk(n < 50, "R10 done arrives", n, 0);
    chk(cpu_rdata == (we ? 32'd0 : last_rdata), "R10 read data", cpu_rdata,
        we ? 32'd0 : last_rdata);
    @(negedge clk);
    chk(!cpu_done && !cfg_req, "R9 no extra cycle / single done", {cpu_done, cfg_req}, 2'b00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cfg_req && !cpu_busy && !cpu_done && !err_flag, "R1 reset",
        {cfg_req, cpu_busy, cpu_done, err_flag}, 4'b0);

    access(1, mk_addr(21'h000004, 3'd5, 6'h3F, 7'h55), 32'hDEAD_BEEF, 4'b1111, 0);
    access(0, mk_addr(21'h000004, 3'd5, 6'h3F, 7'h01), 0, 4'b1111, 0);
    access(0, mk_addr(21'h100000, 3'd7, 6'h00, 7'h7F), 0, 4'b0001, 0);
    access(0, mk_addr(21'h1FFFFF, 3'd0, 6'h10, 7'h00), 0, 4'b0011, 0);
    access(1, mk_addr(21'h000000, 3'd2, 6'h04, 7'h00), 32'h1234_5678, 4'b0101, 0);
    access(0, mk_addr(21'h000000, 3'd2, 6'h04, 7'h00), 0, 4'b1111, 0);
    access(0, mk_addr(21'h000300, 3'd1, 6'h08, 7'h33), 0, 4'b1111, 1);

    set_bus(1);
    access(0, mk_addr(21'h000001, 3'd0, 6'h00, 7'h00), 0, 4'b1111, 0);
    access(1, mk_addr(21'h000002, 3'd1, 6'h01, 7'h00), 32'hFFFF_FFFF, 4'b1111, 0);
    set_bus(0);
    access(0, mk_addr(21'h000002, 3'd1, 6'h01, 7'h00), 0, 4'b1111, 0);
    chk(err_flag, "R11 sticky error", err_flag, 1);

    for (int k = 0; k < 150; k++) begin
      logic [20:0] sel;
      case ($urandom % 4)
        0: sel = 21'd0;
        1: sel = 21'd1 << ($urandom % 21);
        default: sel = 21'($urandom);
      endcase
      access(1'($urandom), mk_addr(sel, 3'($urandom), 6'($urandom), 7'($urandom)),
             $urandom, 4'($urandom), ($urandom % 8) == 0);
    end
    chk(err_flag, "R11 sticky after traffic", err_flag, 1);
    finish_run();
  end
endmodule